// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block drives the timing side of a parallel RGB LCD panel. From a small bank of write-only configuration registers it builds the horizontal and vertical sync pulses, a data-enable strobe and the current pixel column and row. A one-cycle frame-start pulse marks the first cycle of vertical sync and can serve as a vertical-blank event. The block runs on the pixel clock and needs no pixel data. It only supplies the timing that a separate fetch and format path follows.

A power sequencer brings the block up by raising a level-sensitive sync-enable input. While that input is low, the counters rest at zero and every sync output stays at its inactive level. Software may rewrite the timing at any time. The block keeps those writes in shadow registers and copies them into the working set only on a frame boundary, so no frame ever mixes two timings.

Top module: `lcd_timing_gen`

## Requirements
- R1: The registers are written through `cfg_we`/`cfg_addr`/`cfg_wdata`, and each write takes effect on the clock edge where `cfg_we` is high. Address 0 holds the hsync width minus one in bits 15:0 and the vsync width in lines minus one in bits 31:16. Address 1 holds the vertical front porch minus one in bits 15:0 and the vertical back porch as a plain line count in bits 31:16. Address 2 holds the horizontal front porch minus one in bits 15:0 and the horizontal back porch minus one in bits 31:16. Address 3 holds the active width minus one in bits 15:0 and the active height minus one in bits 31:16. Address 4 holds the hsync polarity in bit 0 and the vsync polarity in bit 1. Writes to addresses 5 to 7 change nothing.
- R2: Each line is laid out as active pixels, then front porch, then the hsync pulse, then back porch. `px_x` counts from 0 up to the line total minus one and then wraps to 0. hsync is active exactly while `px_x` lies in the pulse region.
- R3: A frame is laid out in lines in the same order: active, front porch, vsync, back porch. `px_y` advances by one when a line wraps and holds steady within a line. vsync is active for whole lines, and a back porch of zero lines is legal.
- R4: `de` is high, and is always active-high, exactly when `px_x` and `px_y` both lie in their active regions.
- R5: When a polarity bit is 0, the matching sync pulse is driven high while active. When the bit is 1, the pulse is driven low while active.
- R6: `frame_start` is high for exactly one cycle per frame: the cycle with `px_x` = 0 on the first vsync line.
- R7: While sync runs, shadowed register values move into the working timing only at the edge where the last cycle of a frame wraps to column 0, row 0. Writes made during a frame do not alter that frame. During any cycle after an idle cycle, the working timing follows the shadow registers.
- R8: After reset, and one cycle after `sync_en` is sampled low, `px_x` and `px_y` are 0, `de` and `frame_start` are low, and both syncs sit at their inactive levels. When `sync_en` rises, the first enabled cycle shows column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Level from the sequencer that starts the timing |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable, active-high |
| frame_start | output | 1 | One-cycle pulse at the start of vsync |
| px_x | output | 18 | Current column |
| px_y | output | 18 | Current row |

## Verification
A register write and the frame-boundary commit can land on the same clock edge. The bench provokes this by watching its own timing model for the final cycle of a frame and issuing a write in exactly that cycle. The correct outcome is that the frame just starting keeps the previous shadow contents and the new value appears only one frame later. The per-cycle comparison of column, row, syncs and data-enable against the model judges this directly.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int FIELD_W    = 16;
    localparam int REG_W      = 2 * FIELD_W;
    localparam int REG_ADDR_W = 3;

    typedef logic [FIELD_W-1:0] fld_t;

    typedef struct packed {
        fld_t hsw_m1;
        fld_t vsw_m1;
        fld_t vfp_m1;
        fld_t vbp;
        fld_t hfp_m1;
        fld_t hbp_m1;
        fld_t hact_m1;
        fld_t vact_m1;
        logic hpol;
        logic vpol;
    } tg_cfg_t;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_SYNC   = 3'd0,
        REG_VPORCH = 3'd1,
        REG_HPORCH = 3'd2,
        REG_ACTIVE = 3'd3,
        REG_POL    = 3'd4
    } tg_reg_e;

endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
    import lcd_tg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  load,
    output tg_cfg_t               work
);

    typedef struct packed {
        tg_cfg_t shadow;
        tg_cfg_t work;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.work = st_q.shadow;
        end
        if (we) begin
            case (addr)
                REG_SYNC: begin
                    st_d.shadow.hsw_m1 = wdata[FIELD_W-1:0];
                    st_d.shadow.vsw_m1 = wdata[REG_W-1:FIELD_W];
                end
                REG_VPORCH: begin
                    st_d.shadow.vfp_m1 = wdata[FIELD_W-1:0];
                    st_d.shadow.vbp    = wdata[REG_W-1:FIELD_W];
                end
                REG_HPORCH: begin
                    st_d.shadow.hfp_m1 = wdata[FIELD_W-1:0];
                    st_d.shadow.hbp_m1 = wdata[REG_W-1:FIELD_W];
                end
                REG_ACTIVE: begin
                    st_d.shadow.hact_m1 = wdata[FIELD_W-1:0];
                    st_d.shadow.vact_m1 = wdata[REG_W-1:FIELD_W];
                end
                REG_POL: begin
                    st_d.shadow.hpol = wdata[0];
                    st_d.shadow.vpol = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign work = st_q.work;

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W:0]   len_act,
    input  logic [CNT_W:0]   len_fp,
    input  logic [CNT_W:0]   len_sw,
    input  logic [CNT_W:0]   len_bp,
    output logic [CNT_W-1:0] cnt,
    output logic             in_act,
    output logic             in_sync,
    output logic             sync_first,
    output logic             last
);

    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } axis_state_t;

    axis_state_t st_d, st_q;

    logic [SUM_W-1:0] edge_fp, edge_sw, edge_bp, total, cnt_ext;

    always_comb begin
        edge_fp = len_act;
        edge_sw = edge_fp + len_fp;
        edge_bp = edge_sw + len_sw;
        total   = edge_bp + len_bp;
        cnt_ext = {1'b0, st_q.cnt};

        in_act     = cnt_ext < edge_fp;
        in_sync    = (cnt_ext >= edge_sw) && (cnt_ext < edge_bp);
        sync_first = cnt_ext == edge_sw;
        last       = cnt_ext == (total - 1'b1);

        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (last) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // counter never leaves its period (R2 for columns, R3 for rows)
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ext < total);

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int CNT_W = FIELD_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_en,
    input  logic                  cfg_we,
    input  logic [REG_ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic                  hsync,
    output logic                  vsync,
    output logic                  de,
    output logic                  frame_start,
    output logic [CNT_W-1:0]      px_x,
    output logic [CNT_W-1:0]      px_y
);

    localparam int LEN_W = CNT_W + 1;

    typedef struct packed {
        logic run;
    } top_state_t;

    top_state_t st_d, st_q;
    tg_cfg_t    work;

    logic             load, frame_end, h_step, v_step;
    logic             h_act, h_sync, h_first_sync, h_last;
    logic             v_act, v_sync, v_first_sync, v_last;
    logic [LEN_W-1:0] h_len_act, h_len_fp, h_len_sw, h_len_bp;
    logic [LEN_W-1:0] v_len_act, v_len_fp, v_len_sw, v_len_bp;

    always_comb begin
        h_len_act = LEN_W'(work.hact_m1) + 1'b1;
        h_len_fp  = LEN_W'(work.hfp_m1) + 1'b1;
        h_len_sw  = LEN_W'(work.hsw_m1) + 1'b1;
        h_len_bp  = LEN_W'(work.hbp_m1) + 1'b1;
        v_len_act = LEN_W'(work.vact_m1) + 1'b1;
        v_len_fp  = LEN_W'(work.vfp_m1) + 1'b1;
        v_len_sw  = LEN_W'(work.vsw_m1) + 1'b1;
        v_len_bp  = LEN_W'(work.vbp);
    end

    always_comb begin
        st_d.run  = sync_en;
        h_step    = st_q.run;
        v_step    = st_q.run && h_last;
        frame_end = st_q.run && h_last && v_last;
        load      = !st_q.run || frame_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    lcd_tg_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .load  (load),
        .work  (work)
    );

    lcd_tg_axis #(.CNT_W(CNT_W)) u_hcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!sync_en),
        .step       (h_step),
        .len_act    (h_len_act),
        .len_fp     (h_len_fp),
        .len_sw     (h_len_sw),
        .len_bp     (h_len_bp),
        .cnt        (px_x),
        .in_act     (h_act),
        .in_sync    (h_sync),
        .sync_first (h_first_sync),
        .last       (h_last)
    );

    lcd_tg_axis #(.CNT_W(CNT_W)) u_vcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!sync_en),
        .step       (v_step),
        .len_act    (v_len_act),
        .len_fp     (v_len_fp),
        .len_sw     (v_len_sw),
        .len_bp     (v_len_bp),
        .cnt        (px_y),
        .in_act     (v_act),
        .in_sync    (v_sync),
        .sync_first (v_first_sync),
        .last       (v_last)
    );

    always_comb begin
        hsync       = (st_q.run && h_sync) ^ work.hpol;
        vsync       = (st_q.run && v_sync) ^ work.vpol;
        de          = st_q.run && h_act && v_act;
        frame_start = st_q.run && (px_x == '0) && v_first_sync;
    end

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |=> (px_x == '0 && px_y == '0 && !de && !frame_start));

    assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && px_x != '0) |-> px_x == $past(px_x) + 1'b1);

    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && px_x != '0) |-> px_y == $past(px_y));

    assert_de_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (px_x <= CNT_W'(work.hact_m1) && px_y <= CNT_W'(work.vact_m1)));

    assert_fs_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_fs_col0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> px_x == '0);

endmodule

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;

    localparam int CW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          hsync, vsync, de, frame_start;
    logic [CW-1:0] px_x, px_y;

    always #4 clk = ~clk;

    lcd_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start),
        .px_x(px_x), .px_y(px_y)
    );

    typedef struct {
        int hsw, vsw, vfp, vbp, hfp, hbp, ha, va;
        bit hp, vp;
    } mcfg_t;

    mcfg_t m_sh, m_wk;
    int    m_h, m_v;
    bit    m_run;
    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string phase = "R2";

    function automatic int htot(mcfg_t c);
        return (c.ha + 1) + (c.hfp + 1) + (c.hsw + 1) + (c.hbp + 1);
    endfunction
    function automatic int vtot(mcfg_t c);
        return (c.va + 1) + (c.vfp + 1) + (c.vsw + 1) + c.vbp;
    endfunction
    function automatic bit e_hs(mcfg_t c, bit run, int h);
        int s = (c.ha + 1) + (c.hfp + 1);
        return (run && h >= s && h < s + c.hsw + 1) ^ c.hp;
    endfunction
    function automatic bit e_vs(mcfg_t c, bit run, int v);
        int s = (c.va + 1) + (c.vfp + 1);
        return (run && v >= s && v < s + c.vsw + 1) ^ c.vp;
    endfunction
    function automatic bit e_de(mcfg_t c, bit run, int h, int v);
        return run && h <= c.ha && v <= c.va;
    endfunction
    function automatic bit e_fs(mcfg_t c, bit run, int h, int v);
        return run && h == 0 && v == (c.va + 1) + (c.vfp + 1);
    endfunction

    // timing model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sh = '{default: 0};
            m_wk = '{default: 0};
            m_h = 0; m_v = 0; m_run = 0;
        end else begin
            int  ht, vt;
            bit  bnd;
            ht  = htot(m_wk);
            vt  = vtot(m_wk);
            bnd = m_run && m_h == ht - 1 && m_v == vt - 1;
            if (!sync_en) begin
                m_h = 0; m_v = 0;
            end else if (m_run) begin
                if (m_h == ht - 1) begin
                    m_h = 0;
                    m_v = (m_v == vt - 1) ? 0 : m_v + 1;
                end else begin
                    m_h = m_h + 1;
                end
            end
            if (!m_run || bnd) m_wk = m_sh;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: begin m_sh.hsw = cfg_wdata[15:0]; m_sh.vsw = cfg_wdata[31:16]; end
                    3'd1: begin m_sh.vfp = cfg_wdata[15:0]; m_sh.vbp = cfg_wdata[31:16]; end
                    3'd2: begin m_sh.hfp = cfg_wdata[15:0]; m_sh.hbp = cfg_wdata[31:16]; end
                    3'd3: begin m_sh.ha  = cfg_wdata[15:0]; m_sh.va  = cfg_wdata[31:16]; end
                    3'd4: begin m_sh.hp  = cfg_wdata[0];    m_sh.vp  = cfg_wdata[1];     end
                    default: ;
                endcase
            end
            m_run = sync_en;
        end
    end

    task automatic chk(string what, string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s [%s] %s got %0d expected %0d at t=%0t", req, phase, what, got, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            chk("px_x",        "R2", int'(px_x), m_h);
            chk("hsync",       "R2", hsync, e_hs(m_wk, m_run, m_h));
            chk("px_y",        "R3", int'(px_y), m_v);
            chk("vsync",       "R3", vsync, e_vs(m_wk, m_run, m_v));
            chk("de",          "R4", de, e_de(m_wk, m_run, m_h, m_v));
            chk("frame_start", "R6", frame_start, e_fs(m_wk, m_run, m_h, m_v));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(int hsw, int vsw, int vfp, int vbp, int hfp, int hbp,
                        int ha, int va, bit hp, bit vp);
        wr(3'd0, {16'(vsw), 16'(hsw)});
        wr(3'd1, {16'(vbp), 16'(vfp)});
        wr(3'd2, {16'(hbp), 16'(hfp)});
        wr(3'd3, {16'(va), 16'(ha)});
        wr(3'd4, {30'd0, vp, hp});
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired, got hung run expected completion");
            end_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        phase = "R8";
        chk("px_x reset", "R8", int'(px_x), 0);
        chk("px_y reset", "R8", int'(px_y), 0);
        chk("de reset",   "R8", de, 0);
        chk("fs reset",   "R8", frame_start, 0);
        chk("hsync reset","R8", hsync, 0);
        chk("vsync reset","R8", vsync, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;

        // R1/R2/R3: basic programmed frame
        phase = "R1";
        prog(2, 1, 0, 1, 1, 1, 7, 3, 0, 0);
        sync_en = 1'b1;
        run(2 * 15 * 9 + 10);

        // R3: zero-line vertical back porch, R5: both polarities inverted
        phase = "R5";
        sync_en = 1'b0; run(3);
        prog(0, 0, 1, 0, 0, 2, 5, 2, 1, 1);
        sync_en = 1'b1;
        run(400);

        // R1: writes to unused addresses change nothing
        phase = "R1";
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0003_0003);
        wr(3'd7, 32'h0001_0002);
        run(300);

        // R7: mid-frame write waits for the frame boundary
        phase = "R7";
        wr(3'd3, {16'd1, 16'd3});
        wr(3'd4, 32'd1);
        run(300);

        // R7: write in the very cycle of the commit edge
        phase = "R7";
        while (!(m_run && m_h == htot(m_wk) - 1 && m_v == vtot(m_wk) - 1)) @(negedge clk);
        wr(3'd2, {16'd0, 16'd3});
        run(400);

        // R8: disable mid-frame, then restart
        phase = "R8";
        run(7);
        sync_en = 1'b0;
        run(5);
        sync_en = 1'b1;
        run(200);

        // random configurations, writes and enable toggles
        phase = "RND";
        for (int it = 0; it < 25; it++) begin
            int kind = $urandom_range(0, 3);
            if (kind == 0) begin
                sync_en = 1'b0;
                run($urandom_range(1, 4));
                sync_en = 1'b1;
            end
            wr(3'($urandom_range(0, 7)),
               {16'($urandom_range(0, 4)), 16'($urandom_range(0, 5))});
            run($urandom_range(50, 700));
        end

        chk_on = 1'b0;
        end_run();
    end

endmodule